// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the addressing fields of a decoded instruction into the 24-bit memory address of its operand. It holds eight 32-bit address registers. A 3-bit mode selects how the address is formed: from a register alone, from a register plus a displacement, from a register with automatic stepping, or from an absolute field carried in the instruction. The address is produced combinationally in the same cycle that the fields are presented.

The auto-increment and auto-decrement modes step the full 32-bit register by the operand size. The new value is written back on the clock edge where a one-cycle commit strobe is high. Only the low 24 bits ever reach memory. A misalignment flag marks word and longword operands that sit on an odd address; the address is still produced. A separate load port lets the test environment place values in the registers. A synchronous reset clears all of them to zero.

Top module: `ea_unit`

## Requirements
- R1: With mode 0 (register), `ea` equals bits 23:0 of the selected register.
- R2: With mode 1, `imm[15:0]` is sign-extended and added to the selected register. With mode 2, `imm[23:0]` is added. In both cases `ea` is bits 23:0 of the 32-bit sum.
- R3: With mode 3 (post-increment), `ea` is bits 23:0 of the register before any update. `wb_value` is the register plus the step: 1, 2 or 4 for `size` 0 (byte), 1 (word), 2 or 3 (longword).
- R4: With mode 4 (pre-decrement), the step from R3 is subtracted from the 32-bit register. `ea` is bits 23:0 of that result and `wb_value` is the full result. This wraps modulo 2^32.
- R5: With mode 5, `ea` is 0xFFFF followed by `imm[7:0]`. The upper field bits are ignored.
- R6: With mode 6, `imm[15:0]` is sign-extended to 24 bits. With mode 7, `imm[23:0]` is used unchanged.
- R7: `misaligned` is 1 exactly when `size` is not 0 and `ea[0]` is 1. For pre-decrement, this tests the decremented address.
- R8: When `commit` is high in mode 3 or 4, the selected register takes `wb_value` on the rising clock edge. Carries and borrows propagate through all 32 bits. `wb_en` is high in exactly these two modes.
- R9: In modes 0, 1, 2, 5, 6 and 7, or while `commit` is low, no register changes.
- R10: A synchronous `rst` high on a rising edge clears all eight registers to zero.
- R11: `ld_en` writes `ld_data` into register `ld_idx` on the rising edge. If a commit falls in the same cycle, the load wins and the commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Addressing mode 0..7 |
| reg_idx | input | 3 | Address register selector |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| imm | input | 24 | Displacement or absolute field |
| commit | input | 1 | Write-back strobe for stepping modes |
| ld_en | input | 1 | Register load enable |
| ld_idx | input | 3 | Register load index |
| ld_data | input | 32 | Register load value |
| ea | output | 24 | Effective address |
| misaligned | output | 1 | Odd address for a word or longword operand |
| wb_en | output | 1 | Current mode updates its register |
| wb_value | output | 32 | Updated register value |

## Verification
A wrong register value is not seen on its own. It shows up on the next cycle in which that register is read through `ea` or `wb_value`. The bench therefore reads every register back in mode 0 or mode 3 one cycle after each write or after each commit that should be ignored. The upper eight register bits never reach `ea`, so a lost carry into bit 24 is caught only by a second step that exposes it through `wb_value`.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int NREG   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              mode,
  input  logic [$clog2(NREG)-1:0] reg_idx,
  input  logic [1:0]              size,
  input  logic [ADDR_W-1:0]       imm,
  input  logic                    commit,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [REG_W-1:0]        ld_data,
  output logic [ADDR_W-1:0]       ea,
  output logic                    misaligned,
  output logic                    wb_en,
  output logic [REG_W-1:0]        wb_value
);
  localparam logic [2:0] M_REG = 3'd0, M_D16 = 3'd1, M_D24 = 3'd2, M_INC = 3'd3,
                         M_DEC = 3'd4, M_A8  = 3'd5, M_A16 = 3'd6, M_A24 = 3'd7;

  logic [NREG-1:0][REG_W-1:0] bank;
  logic [REG_W-1:0] cur, step, sum;

  assign cur  = bank[reg_idx];
  assign step = (size == 2'd0) ? REG_W'(1) : (size == 2'd1) ? REG_W'(2) : REG_W'(4);

  always_comb begin
    case (mode)
      M_D16:   sum = cur + {{(REG_W-16){imm[15]}}, imm[15:0]};
      M_D24:   sum = cur + {{(REG_W-ADDR_W){1'b0}}, imm};
      M_INC:   sum = cur + step;
      M_DEC:   sum = cur - step;
      default: sum = cur;
    endcase
  end

  always_comb begin
    case (mode)
      M_D16, M_D24, M_DEC: ea = sum[ADDR_W-1:0];
      M_A8:    ea = {{(ADDR_W-8){1'b1}}, imm[7:0]};
      M_A16:   ea = {{(ADDR_W-16){imm[15]}}, imm[15:0]};
      M_A24:   ea = imm;
      default: ea = cur[ADDR_W-1:0];
    endcase
  end

  assign wb_en      = (mode == M_INC) || (mode == M_DEC);
  assign wb_value   = sum;
  assign misaligned = (size != 2'd0) && ea[0];

  always_ff @(posedge clk) begin
    if (rst)                 bank <= '0;
    else if (ld_en)          bank[ld_idx] <= ld_data;
    else if (commit && wb_en) bank[reg_idx] <= wb_value;
  end

  a_r8_commit_writes: assert property (@(posedge clk) disable iff (rst)
    (commit && wb_en && !ld_en) |=> bank[$past(reg_idx)] == $past(wb_value));

  a_r9_bank_holds: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !(commit && wb_en)) |=> $stable(bank));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> bank[$past(ld_idx)] == $past(ld_data));

  a_r4_dec_address: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DEC) |-> ea == wb_value[ADDR_W-1:0]);

  a_r5_top_page: assert property (@(posedge clk) disable iff (rst)
    (mode == M_A8) |-> &ea[ADDR_W-1:8]);

  a_r7_flag_even: assert property (@(posedge clk) disable iff (rst)
    (size == 2'd0) |-> !misaligned);
endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [2:0] mode = 0, reg_idx = 0, ld_idx = 0;
  logic [1:0] size = 0;
  logic [23:0] imm = 0;
  logic commit = 0, ld_en = 0;
  logic [31:0] ld_data = 0;
  logic [23:0] ea;
  logic misaligned, wb_en;
  logic [31:0] wb_value;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_unit i_ea_unit (.clk(clk), .rst(rst), .mode(mode), .reg_idx(reg_idx), .size(size),
    .imm(imm), .commit(commit), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .ea(ea), .misaligned(misaligned), .wb_en(wb_en), .wb_value(wb_value));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] d);
    ld_en = 1; ld_idx = idx; ld_data = d; tick(); ld_en = 0;
  endtask

  task automatic apply(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                       input logic [23:0] f);
    mode = m; reg_idx = r; size = s; imm = f; #1;
  endtask

  task automatic do_commit();
    commit = 1; tick(); commit = 0; #1;
  endtask

  task automatic t_reset();
    load(3'd2, 32'h12345678);
    rst = 1; tick(); rst = 0;
    for (int i = 0; i < 8; i++) begin
      apply(3'd3, 3'(i), 2'd0, 24'h0);
      chk("R10 reset ea", 32'(ea), 32'h0);
      chk("R10 reset upper", wb_value, 32'h1);
    end
  endtask

  task automatic t_indirect();
    load(3'd2, 32'hAB123456);
    apply(3'd0, 3'd2, 2'd0, 24'hFFFFFF);
    chk("R1 register", 32'(ea), 32'h123456);
    chk("R8 wb_en low in mode 0", 32'(wb_en), 32'h0);
  endtask

  task automatic t_disp();
    load(3'd1, 32'h00001000);
    apply(3'd1, 3'd1, 2'd0, 24'hABFFF0);
    chk("R2 negative d16", 32'(ea), 32'h000FF0);
    apply(3'd1, 3'd1, 2'd0, 24'h007FFF);
    chk("R2 positive d16", 32'(ea), 32'h008FFF);
    load(3'd1, 32'h00FFFF00);
    apply(3'd2, 3'd1, 2'd0, 24'h000200);
    chk("R2 d24 wrap", 32'(ea), 32'h000100);
  endtask

  task automatic t_postinc();
    load(3'd3, 32'h00000100);
    apply(3'd3, 3'd3, 2'd1, 24'h0);
    chk("R3 ea before step", 32'(ea), 32'h000100);
    chk("R3 word step", wb_value, 32'h00000102);
    chk("R8 wb_en mode 3", 32'(wb_en), 32'h1);
    do_commit();
    apply(3'd0, 3'd3, 2'd0, 24'h0);
    chk("R8 post-inc stored", 32'(ea), 32'h000102);
    apply(3'd3, 3'd3, 2'd2, 24'h0);
    chk("R3 long step", wb_value, 32'h00000106);
    do_commit();
    apply(3'd3, 3'd3, 2'd3, 24'h0);
    chk("R3 size 3 step", wb_value, 32'h0000010A);
    apply(3'd3, 3'd3, 2'd0, 24'h0);
    chk("R3 byte ea", 32'(ea), 32'h000106);
    chk("R3 byte step", wb_value, 32'h00000107);
    load(3'd4, 32'h00FFFFFF);
    apply(3'd3, 3'd4, 2'd0, 24'h0);
    do_commit();
    apply(3'd0, 3'd4, 2'd0, 24'h0);
    chk("R8 carry low bits", 32'(ea), 32'h000000);
    apply(3'd3, 3'd4, 2'd0, 24'h0);
    chk("R8 carry into bit 24", wb_value, 32'h01000001);
  endtask

  task automatic t_predec();
    load(3'd5, 32'h00000200);
    apply(3'd4, 3'd5, 2'd2, 24'h0);
    chk("R4 long ea", 32'(ea), 32'h0001FC);
    chk("R4 long wb", wb_value, 32'h000001FC);
    do_commit();
    apply(3'd0, 3'd5, 2'd0, 24'h0);
    chk("R8 pre-dec stored", 32'(ea), 32'h0001FC);
    apply(3'd4, 3'd5, 2'd0, 24'h0);
    chk("R4 byte ea", 32'(ea), 32'h0001FB);
    load(3'd6, 32'h0);
    apply(3'd4, 3'd6, 2'd1, 24'h0);
    chk("R4 wrap ea", 32'(ea), 32'hFFFFFE);
    chk("R4 wrap wb", wb_value, 32'hFFFFFFFE);
  endtask

  task automatic t_abs();
    apply(3'd5, 3'd0, 2'd0, 24'h000034);
    chk("R5 abs8", 32'(ea), 32'hFFFF34);
    apply(3'd5, 3'd0, 2'd0, 24'h123480);
    chk("R5 abs8 upper ignored", 32'(ea), 32'hFFFF80);
    apply(3'd6, 3'd0, 2'd0, 24'h008000);
    chk("R6 abs16 negative", 32'(ea), 32'hFF8000);
    apply(3'd6, 3'd0, 2'd0, 24'hAB1234);
    chk("R6 abs16 positive", 32'(ea), 32'h001234);
    apply(3'd7, 3'd0, 2'd0, 24'hABCDEF);
    chk("R6 abs24", 32'(ea), 32'hABCDEF);
  endtask

  task automatic t_misalign();
    apply(3'd7, 3'd0, 2'd0, 24'h000001);
    chk("R7 byte odd", 32'(misaligned), 32'h0);
    apply(3'd7, 3'd0, 2'd1, 24'h000001);
    chk("R7 word odd", 32'(misaligned), 32'h1);
    chk("R7 address kept", 32'(ea), 32'h000001);
    apply(3'd7, 3'd0, 2'd2, 24'h000002);
    chk("R7 long even", 32'(misaligned), 32'h0);
    load(3'd1, 32'h00000103);
    apply(3'd4, 3'd1, 2'd1, 24'h0);
    chk("R7 pre-dec result odd", 32'(misaligned), 32'h1);
    load(3'd1, 32'h00000102);
    apply(3'd4, 3'd1, 2'd2, 24'h0);
    chk("R7 pre-dec result even", 32'(misaligned), 32'h0);
  endtask

  task automatic t_nowrite();
    load(3'd7, 32'h00000500);
    apply(3'd0, 3'd7, 2'd2, 24'h0);  do_commit();
    apply(3'd1, 3'd7, 2'd2, 24'h10); do_commit();
    apply(3'd5, 3'd7, 2'd2, 24'h10); do_commit();
    apply(3'd3, 3'd7, 2'd2, 24'h0);  tick();
    apply(3'd4, 3'd7, 2'd2, 24'h0);  tick();
    apply(3'd3, 3'd7, 2'd0, 24'h0);
    chk("R9 register untouched ea", 32'(ea), 32'h000500);
    chk("R9 register untouched full", wb_value, 32'h00000501);
  endtask

  task automatic t_load_prio();
    load(3'd0, 32'h00000010);
    apply(3'd3, 3'd0, 2'd2, 24'h0);
    ld_en = 1; ld_idx = 3'd0; ld_data = 32'h00000040; commit = 1;
    tick();
    ld_en = 0; commit = 0;
    apply(3'd0, 3'd0, 2'd0, 24'h0);
    chk("R11 load beats commit", 32'(ea), 32'h000040);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    t_reset();
    t_indirect();
    t_disp();
    t_postinc();
    t_predec();
    t_abs();
    t_misalign();
    t_nowrite();
    t_load_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule